// File: doc/BRIEF.md
# Redirected Interrupt Pin Controller

This block sits between a bank of interrupt request lines and an interrupt fabric that accepts message writes. Each line owns a programmable redirection entry. The entry selects the vector, the delivery mode, the destination, the destination mode, edge or level sensing, and a mask. The block turns activity on each line into a pending state. It then issues one message per delivery on a valid/ready port, as a 32-bit address word and a 32-bit data word.

Lines sensed by level carry an in-service flag. The flag is set when the line is delivered and it blocks any further delivery from that line. Edge requests that arrive while the line is masked are thrown away. Entries are written through a plain load port, one whole 64-bit entry per cycle. The in-service flag cannot be written through that port. It is cleared only when the entry is switched to edge sensing, or by reset.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: After reset no message is pending, `msg_valid` is low, and every entry is masked, so no activity on any line produces a message until an entry is loaded with its mask bit (bit 16) clear.
- R2: Request line 0 is routed to entry 2 (line 2 and line 0 are ORed into entry 2); entry 0 is never served; every other line uses the entry with its own index.
- R3: With bit 15 of the entry set (level sensing), the pending bit follows the line: high sets it, and low clears it, so a level pulse seen only while masked leaves nothing to deliver after unmasking.
- R4: With bit 15 clear (edge sensing), a low-to-high transition on the line becomes pending only if the mask bit is clear; transitions seen while masked are lost.
- R5: A pending line whose mask bit is set is passed over but keeps its pending state, and it is delivered once the mask is cleared.
- R6: When several lines are eligible, the lowest entry index is delivered first.
- R7: Delivering an edge-sensed line clears its pending bit, so one transition yields exactly one message even if the line stays high.
- R8: Delivering a level-sensed line sets its in-service flag; while that flag is set, the line produces no further message, whatever the line does.
- R9: `msg_addr` = 0xFEE00000 OR (entry bits 63:48 shifted left by 12) OR (entry bit 11 shifted left by 2).
- R10: `msg_data` holds the vector (entry bits 7:0) at bits 7:0, the delivery mode (entry bits 10:8) at bits 10:8, and the sensing bit (entry bit 15) at bit 15; all other bits are zero.
- R11: At most one message is issued per cycle; while `msg_valid` is high and `msg_ready` is low, the message holds unchanged and no new one is chosen.
- R12: Loading an entry keeps its in-service flag if the new entry is level-sensed, and clears the flag if the new entry is edge-sensed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pins | input | NUM_PINS | Interrupt request lines, sampled each cycle |
| ld_valid | input | 1 | Writes `ld_entry` into entry `ld_pin` this cycle |
| ld_pin | input | clog2(NUM_PINS) | Entry index for the load; values at or above NUM_PINS are ignored |
| ld_entry | input | 64 | New redirection entry (bit 14 is ignored) |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Receiver accepts the message this cycle |
| msg_addr | output | 32 | Message address word |
| msg_data | output | 32 | Message data word |

## Verification
The assertions assume that `msg_ready` is a plain per-cycle accept and that the receiver never needs a message withdrawn. They also assume that load indices above the entry count arrive only as stray values and never as intended writes. The stimulus drives every input half a cycle away from the active edge. It holds lines stable for whole cycles and raises `msg_ready` only when a test intends a transfer. Each load is issued while the block is otherwise idle or deliberately stalled, so the entry seen at delivery time is never ambiguous.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

   localparam int ENTRY_W       = 64;
   localparam int VEC_LSB       = 0;
   localparam int DLV_LSB       = 8;
   localparam int DSTMODE_BIT   = 11;
   localparam int SENSE_BIT     = 15;
   localparam int MASK_BIT      = 16;
   localparam int DEST_LSB      = 48;

   localparam logic [31:0] ADDR_BASE = 32'hFEE0_0000;
   localparam int ADDR_DEST_LSB    = 12;
   localparam int ADDR_DSTMODE_BIT = 2;
   localparam int DATA_DLV_LSB     = 8;
   localparam int DATA_SENSE_BIT   = 15;

   typedef struct packed {
      logic [15:0] dest;
      logic        mask;
      logic        sense;    // 1: level, 0: edge
      logic        dstmode;
      logic [2:0]  dlv;
      logic [7:0]  vec;
   } redir_fields_t;

   localparam redir_fields_t FIELDS_RESET = '{dest: 16'h0, mask: 1'b1, sense: 1'b0,
                                             dstmode: 1'b0, dlv: 3'h0, vec: 8'h0};

   function automatic redir_fields_t pick_fields(input logic [ENTRY_W-1:0] e);
      redir_fields_t f;
      f.dest    = e[DEST_LSB +: 16];
      f.mask    = e[MASK_BIT];
      f.sense   = e[SENSE_BIT];
      f.dstmode = e[DSTMODE_BIT];
      f.dlv     = e[DLV_LSB +: 3];
      f.vec     = e[VEC_LSB +: 8];
      return f;
   endfunction

   function automatic logic [31:0] form_addr(input redir_fields_t f);
      return ADDR_BASE | (32'(f.dest) << ADDR_DEST_LSB)
                       | (32'(f.dstmode) << ADDR_DSTMODE_BIT);
   endfunction

   function automatic logic [31:0] form_data(input redir_fields_t f);
      return 32'(f.vec) | (32'(f.dlv) << DATA_DLV_LSB)
                        | (32'(f.sense) << DATA_SENSE_BIT);
   endfunction

endpackage

// File: rtl/irq_line_intake.sv
module irq_line_intake #(
   parameter int NUM_PINS   = 24,
   parameter bit REMAP_ZERO = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins_in,
   output logic [NUM_PINS-1:0] line_o,
   output logic [NUM_PINS-1:0] rise_o
);
   logic [NUM_PINS-1:0] line_prev_q;

   generate
      if (REMAP_ZERO) begin : g_remap
         always_comb begin
            line_o    = pins_in;
            line_o[2] = pins_in[0] | pins_in[2];
            line_o[0] = 1'b0;
         end
      end else begin : g_direct
         assign line_o = pins_in;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) line_prev_q <= '0;
      else        line_prev_q <= line_o;
   end

   assign rise_o = line_o & ~line_prev_q;
endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
   parameter int NUM_PINS = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] line_i,
   input  logic [NUM_PINS-1:0] rise_i,
   input  logic [NUM_PINS-1:0] mask_i,
   input  logic [NUM_PINS-1:0] level_i,
   input  logic [NUM_PINS-1:0] served_i,
   output logic [NUM_PINS-1:0] pend_o
);
   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         always_ff @(posedge clk) begin
            if (!rst_n)                      pend_o[i] <= 1'b0;
            else if (level_i[i])             pend_o[i] <= line_i[i];
            else if (rise_i[i] && !mask_i[i]) pend_o[i] <= 1'b1;
            else if (served_i[i])            pend_o[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/irq_entry_table.sv
module irq_entry_table
   import irq_redir_pkg::*;
#(
   parameter int NUM_PINS = 24,
   parameter int IDX_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ld_valid,
   input  logic [IDX_W-1:0]    ld_pin,
   input  logic [ENTRY_W-1:0]  ld_entry,
   input  logic [NUM_PINS-1:0] set_remote_i,
   input  logic [IDX_W-1:0]    sel_idx,
   output redir_fields_t       sel_fields,
   output logic [NUM_PINS-1:0] mask_o,
   output logic [NUM_PINS-1:0] level_o,
   output logic [NUM_PINS-1:0] remote_o
);
   redir_fields_t fields_q [NUM_PINS];
   redir_fields_t ld_fields;

   assign ld_fields = pick_fields(ld_entry);

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
         localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
         logic hit;
         assign hit = ld_valid && (ld_pin == MY_IDX);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               fields_q[i] <= FIELDS_RESET;
               remote_o[i] <= 1'b0;
            end else begin
               if (hit) fields_q[i] <= ld_fields;
               if (hit && !ld_fields.sense) remote_o[i] <= 1'b0;
               else if (set_remote_i[i])    remote_o[i] <= 1'b1;
            end
         end

         assign mask_o[i]  = fields_q[i].mask;
         assign level_o[i] = fields_q[i].sense;
      end
   endgenerate

   always_comb begin
      sel_fields = FIELDS_RESET;
      for (int i = 0; i < NUM_PINS; i++)
         if (sel_idx == IDX_W'(i)) sel_fields = fields_q[i];
   end
endmodule

// File: rtl/irq_pick_lowest.sv
module irq_pick_lowest #(
   parameter int NUM_PINS = 24,
   parameter int IDX_W    = 5
) (
   input  logic [NUM_PINS-1:0] req_i,
   output logic [NUM_PINS-1:0] grant_o,
   output logic [IDX_W-1:0]    idx_o,
   output logic                any_o
);
   always_comb begin
      grant_o = '0;
      idx_o   = '0;
      any_o   = 1'b0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (!any_o && req_i[i]) begin
            grant_o[i] = 1'b1;
            idx_o      = IDX_W'(i);
            any_o      = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
   import irq_redir_pkg::*;
#(
   parameter int NUM_PINS   = 24,
   parameter bit REMAP_ZERO = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PINS-1:0]         irq_pins,
   input  logic                        ld_valid,
   input  logic [$clog2(NUM_PINS)-1:0] ld_pin,
   input  logic [63:0]                 ld_entry,
   output logic                        msg_valid,
   input  logic                        msg_ready,
   output logic [31:0]                 msg_addr,
   output logic [31:0]                 msg_data
);
   localparam int IDX_W = $clog2(NUM_PINS);

   generate
      if (NUM_PINS < 3 || NUM_PINS > 32) begin : g_bad_cfg
         $error("irq_redirect_ctrl: NUM_PINS must lie in 3..32");
      end
   endgenerate

   logic [NUM_PINS-1:0] line_vec, rise_vec, pend_vec;
   logic [NUM_PINS-1:0] mask_vec, level_vec, remote_vec;
   logic [NUM_PINS-1:0] cand_vec, grant_vec, issue_vec;
   logic [IDX_W-1:0]    grant_idx;
   logic                grant_any, slot_free, issue;
   redir_fields_t       sel_fields;

   irq_line_intake #(.NUM_PINS(NUM_PINS), .REMAP_ZERO(REMAP_ZERO)) u_intake (
      .clk(clk), .rst_n(rst_n), .pins_in(irq_pins),
      .line_o(line_vec), .rise_o(rise_vec));

   irq_pending_bank #(.NUM_PINS(NUM_PINS)) u_pend (
      .clk(clk), .rst_n(rst_n), .line_i(line_vec), .rise_i(rise_vec),
      .mask_i(mask_vec), .level_i(level_vec),
      .served_i(issue_vec & ~level_vec), .pend_o(pend_vec));

   irq_entry_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_table (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pin(ld_pin),
      .ld_entry(ld_entry), .set_remote_i(issue_vec & level_vec),
      .sel_idx(grant_idx), .sel_fields(sel_fields),
      .mask_o(mask_vec), .level_o(level_vec), .remote_o(remote_vec));

   assign cand_vec = pend_vec & ~mask_vec & ~(level_vec & remote_vec);

   irq_pick_lowest #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_pick (
      .req_i(cand_vec), .grant_o(grant_vec), .idx_o(grant_idx), .any_o(grant_any));

   assign slot_free = !msg_valid || msg_ready;
   assign issue     = grant_any && slot_free;
   assign issue_vec = grant_vec & {NUM_PINS{issue}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg_addr  <= '0;
         msg_data  <= '0;
      end else if (issue) begin
         msg_valid <= 1'b1;
         msg_addr  <= form_addr(sel_fields);
         msg_data  <= form_data(sel_fields);
      end else if (msg_ready) begin
         msg_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_redirect_ctrl_chk.sv
module irq_redirect_ctrl_chk #(
   parameter int NUM_PINS   = 24,
   parameter bit REMAP_ZERO = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                msg_valid,
   input logic                msg_ready,
   input logic [31:0]         msg_addr,
   input logic [31:0]         msg_data,
   input logic [NUM_PINS-1:0] pend,
   input logic [NUM_PINS-1:0] remote,
   input logic [NUM_PINS-1:0] mask,
   input logic [NUM_PINS-1:0] level,
   input logic [NUM_PINS-1:0] grant
);
   assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

   assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_addr_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> msg_addr[31:28] == 4'hF && msg_addr[11:3] == '0 && msg_addr[1:0] == '0);

   assert_data_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> msg_data[31:16] == '0 && msg_data[14:11] == '0);

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         assert_masked_edge_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[i]) && !$past(level[i]) |-> !$past(mask[i]));

         assert_grant_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> pend[i] && !mask[i]);

         assert_no_redeliver_R8: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] && level[i] |-> !remote[i]);
      end
      if (REMAP_ZERO) begin : g_line0
         assert_line0_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !pend[0]);
      end
   endgenerate
endmodule

bind irq_redirect_ctrl irq_redirect_ctrl_chk #(.NUM_PINS(NUM_PINS), .REMAP_ZERO(REMAP_ZERO)) i_chk (
   .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
   .msg_addr(msg_addr), .msg_data(msg_data), .pend(pend_vec), .remote(remote_vec),
   .mask(mask_vec), .level(level_vec), .grant(grant_vec));

// File: tb/test_irq_redirect_ctrl.sv
module test_irq_redirect_ctrl;
   localparam int NP = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NP-1:0] pins = '0;
   logic        ld_valid = 1'b0;
   logic [4:0]  ld_pin = '0;
   logic [63:0] ld_entry = '0;
   logic        msg_ready = 1'b1;
   logic        msg_valid;
   logic [31:0] msg_addr, msg_data;

   int n_checks = 0;
   int n_errors = 0;
   int log_n = 0;
   logic [31:0] log_addr [0:127];
   logic [31:0] log_data [0:127];

   always #2.5 clk = ~clk;

   irq_redirect_ctrl #(.NUM_PINS(NP)) i_irq_redirect_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_pins(pins), .ld_valid(ld_valid),
      .ld_pin(ld_pin), .ld_entry(ld_entry), .msg_valid(msg_valid),
      .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

   always @(negedge clk) begin
      #1;
      if (rst_n && msg_valid && msg_ready && log_n < 128) begin
         log_addr[log_n] = msg_addr;
         log_data[log_n] = msg_data;
         log_n = log_n + 1;
      end
   end

   function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dlv,
      input logic dm, input logic lvl, input logic msk, input logic [15:0] dest);
      return {dest, 31'b0, msk, lvl, 3'b0, dm, dlv, vec};
   endfunction

   function automatic logic [31:0] x_addr(input logic [63:0] e);
      return 32'hFEE0_0000 | ({16'h0, e[63:48]} << 12) | ({31'h0, e[11]} << 2);
   endfunction

   function automatic logic [31:0] x_data(input logic [63:0] e);
      return {24'h0, e[7:0]} | ({29'h0, e[10:8]} << 8) | ({31'h0, e[15]} << 15);
   endfunction

   function automatic logic [63:0] sweep_entry(input int p);
      return mk(8'(8'h30 + p), 3'(p % 8), 1'(p & 1), 1'b0, 1'b0, 16'(p * 16'h0A03));
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load(input int p, input logic [63:0] e);
      ld_valid = 1'b1; ld_pin = 5'(p); ld_entry = e;
      tick(1);
      ld_valid = 1'b0;
   endtask

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic check_msg(input string tag, input int k, input logic [63:0] e);
      check({tag, " addr"}, 64'(log_addr[k]), 64'(x_addr(e)));
      check({tag, " data"}, 64'(log_data[k]), 64'(x_data(e)));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      int b;
      logic [63:0] e3, e7, e12, e13;
      tick(4);
      rst_n = 1'b1;
      tick(1);
      // R1: idle after reset, every entry masked
      check("R1 valid after reset", 64'(msg_valid), 64'd0);
      pins = '1; tick(5); pins = '0; tick(5);
      check("R1 no message while masked", 64'(log_n), 64'd0);
      for (int p = 0; p < NP; p++) load(p, sweep_entry(p));
      tick(5);
      // R4: the earlier masked edges were discarded
      check("R4 masked edges dropped", 64'(log_n), 64'd0);

      // R9 R10 R4 R7: one message per edge, every line
      for (int p = 1; p < NP; p++) begin
         b = log_n;
         pins[p] = 1'b1; tick(1); pins[p] = 1'b0;
         tick(4);
         check($sformatf("R4 count line %0d", p), 64'(log_n - b), 64'd1);
         check_msg($sformatf("R9 R10 line %0d", p), b, sweep_entry(p));
      end
      // R2: line 0 is served by entry 2
      b = log_n;
      pins[0] = 1'b1; tick(1); pins[0] = 1'b0; tick(4);
      check("R2 count line 0", 64'(log_n - b), 64'd1);
      check_msg("R2 line 0 uses entry 2", b, sweep_entry(2));

      // R7: held-high edge line delivers once
      b = log_n;
      pins[5] = 1'b1; tick(10); pins[5] = 1'b0; tick(4);
      check("R7 single message held edge", 64'(log_n - b), 64'd1);

      // R11 R6: stall then priority order
      e3 = sweep_entry(3); e7 = sweep_entry(7); e12 = sweep_entry(12);
      msg_ready = 1'b0; b = log_n;
      pins[3] = 1'b1; pins[7] = 1'b1; pins[12] = 1'b1; tick(1);
      pins = '0; tick(3);
      check("R11 valid while stalled", 64'(msg_valid), 64'd1);
      check("R11 stalled data", 64'(msg_data), 64'(x_data(e3)));
      tick(3);
      check("R11 data held", 64'(msg_data), 64'(x_data(e3)));
      check("R11 addr held", 64'(msg_addr), 64'(x_addr(e3)));
      msg_ready = 1'b1; tick(6);
      check("R6 three messages", 64'(log_n - b), 64'd3);
      check_msg("R6 first lowest", b, e3);
      check_msg("R6 second", b + 1, e7);
      check_msg("R6 third", b + 2, e12);

      // R5: pending edge masked before service waits
      e13 = sweep_entry(13);
      msg_ready = 1'b0; b = log_n;
      pins[3] = 1'b1; pins[13] = 1'b1; tick(1); pins = '0; tick(2);
      load(13, e13 | (64'h1 << 16));
      msg_ready = 1'b1; tick(6);
      check("R5 masked pending skipped", 64'(log_n - b), 64'd1);
      load(13, e13); tick(4);
      check("R5 delivered after unmask", 64'(log_n - b), 64'd2);
      check_msg("R5 unmasked entry", b + 1, e13);

      // R3 R8: level line
      load(9, mk(8'h59, 3'd1, 1'b0, 1'b1, 1'b0, 16'h0042));
      b = log_n;
      pins[9] = 1'b1; tick(12);
      check("R3 level delivered once", 64'(log_n - b), 64'd1);
      check_msg("R3 level format", b, mk(8'h59, 3'd1, 1'b0, 1'b1, 1'b0, 16'h0042));
      pins[9] = 1'b0; tick(2); pins[9] = 1'b1; tick(6);
      check("R8 in-service blocks retrigger", 64'(log_n - b), 64'd1);
      // R12: level reload keeps the flag, edge reload clears it
      load(9, mk(8'h59, 3'd1, 1'b0, 1'b1, 1'b0, 16'h0042)); tick(5);
      check("R12 level reload keeps flag", 64'(log_n - b), 64'd1);
      pins[9] = 1'b0; tick(2);
      load(9, mk(8'h59, 3'd1, 1'b0, 1'b0, 1'b0, 16'h0042));
      load(9, mk(8'h59, 3'd1, 1'b0, 1'b1, 1'b0, 16'h0042));
      pins[9] = 1'b1; tick(5);
      check("R12 edge reload clears flag", 64'(log_n - b), 64'd2);
      pins[9] = 1'b0; tick(2);

      // R3: level pulse while masked leaves nothing pending
      load(10, mk(8'h5A, 3'd0, 1'b1, 1'b1, 1'b1, 16'h0001));
      b = log_n;
      pins[10] = 1'b1; tick(2); pins[10] = 1'b0; tick(2);
      load(10, mk(8'h5A, 3'd0, 1'b1, 1'b1, 1'b0, 16'h0001)); tick(5);
      check("R3 deasserted level not delivered", 64'(log_n - b), 64'd0);

      // R5: held level line masked, then unmasked
      load(11, mk(8'h5B, 3'd2, 1'b1, 1'b1, 1'b1, 16'hBEEF));
      b = log_n;
      pins[11] = 1'b1; tick(3);
      check("R5 masked level held back", 64'(log_n - b), 64'd0);
      load(11, mk(8'h5B, 3'd2, 1'b1, 1'b1, 1'b0, 16'hBEEF)); tick(5);
      check("R5 level after unmask", 64'(log_n - b), 64'd1);
      check_msg("R5 level format", b, mk(8'h5B, 3'd2, 1'b1, 1'b1, 1'b0, 16'hBEEF));
      pins[11] = 1'b0; tick(3);

      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule